// File: doc/BRIEF.md
# Video Memory Cycle Sequencer

This block drives the row-access side of a dynamic serial-access frame memory used in a video noise and flicker filter. It decides which row operation runs next and produces the command strobes, a 3-bit operation code and a row address. Port A is the double-rate output port. Port B is the normal-rate read port. Port C is the normal-rate write port. The memory cells and the serial shift ports are outside the block.

After reset the sequencer stays quiet for a start-up pause. It then issues eight dummy row strobes and raises `ready_o`. From then on it repeats a four-slot main cycle. Port A is read, then port B is read, then port A is read again, then port C is written. Each transfer has an address-load phase before its row strobe. A down-counter raises refresh requests. Each request is served by a refresh operation at the next main-cycle boundary. The refresh row comes from an internal counter, and the port row inputs are not used for it.

With the default parameters and a 100 MHz clock, one operation takes 30 cycles, which is about the 296 ns row cycle of the target memory. The pause is 200 µs. A request is raised every 6000 cycles, so 256 refreshes fit well inside 16 ms.

Top module: `vsam_cycle_seq`

## Requirements
- R1: After synchronous reset is released, all outputs stay at zero for PAUSE_CYC cycles: `cmd_o`=0 (idle), both strobes low, `row_o`=0, `ready_o`=0. The first row strobe rises in cycle PAUSE_CYC, counting from 0 at the first cycle out of reset.
- R2: The pause is followed by exactly INIT_N (default 8) dummy operations. Each one holds `re_strb_o` high with `cmd_o`=1 and `row_o`=0 for RE_CYC cycles, then stays idle for PRE_CYC cycles. A dummy operation has no address phase.
- R3: `ready_o` stays 0 until the precharge of the last dummy operation has finished. It rises in the same cycle as the first main operation and then stays 1 until reset.
- R4: Transfers repeat in this order: read port A (`cmd_o`=2), read port B (`cmd_o`=3), read port A (`cmd_o`=2), write port C (`cmd_o`=4).
- R5: Each transfer takes three phases. First `addr_strb_o` is high for ADDR_CYC cycles. Then `re_strb_o` is high for RE_CYC cycles, with `cmd_o` and `row_o` held through both phases. Then comes PRE_CYC idle cycles with `cmd_o`=0, `row_o`=0 and both strobes low. The two strobes are never high together.
- R6: A refresh operation (`cmd_o`=5) has no address phase. It runs RE_CYC strobe cycles and then PRE_CYC idle cycles. It is placed only before the first port A read of a main cycle, so after a port C write or before the first transfer.
- R7: While `ready_o` is 1, a refresh request is raised every REF_PERIOD cycles. Each request is served at the next main-cycle boundary and no request is lost.
- R8: The row of a refresh comes from an internal counter. The counter starts at 0 after reset, advances by one per refresh and wraps from 2^ROW_W-1 to 0. The inputs `row_a_i`, `row_b_i` and `row_c_i` have no effect on it.
- R9: A transfer takes its row from `row_a_i`, `row_b_i` or `row_c_i`, according to its port, as sampled in the cycle before its address phase. That row is held on `row_o` for the whole operation.
- R10: Asserting reset during normal operation restarts the sequence from the pause, with `ready_o` back at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| row_a_i | input | ROW_W | Row address for port A read transfers |
| row_b_i | input | ROW_W | Row address for port B read transfers |
| row_c_i | input | ROW_W | Row address for port C write transfers |
| addr_strb_o | output | 1 | Address-load phase of a transfer |
| re_strb_o | output | 1 | Row strobe active |
| cmd_o | output | 3 | Operation code: 0 idle, 1 dummy, 2 read A, 3 read B, 4 write C, 5 refresh |
| row_o | output | ROW_W | Row address of the current operation |
| ready_o | output | 1 | Start-up sequence complete |

## Verification
The row inputs are driven in three patterns:
- Fixed, distinct values for the three ports. These separate a port-select fault from a timing fault.
- A shifting pseudo-random value that changes every cycle. This exposes sampling in the wrong cycle and failure to hold the row through an operation.
- Values derived from the cycle count. These change during refresh strobes, so a refresh that reads the inputs is caught.

The run is long enough for the refresh counter to wrap past its top value. It ends with a reset in the middle of operation to confirm that the pause and the dummy phase restart.

// File: rtl/vsam_pkg.sv
package vsam_pkg;

  typedef enum logic [2:0] {
    CMD_IDLE = 3'd0,
    CMD_INIT = 3'd1,
    CMD_RDA  = 3'd2,
    CMD_RDB  = 3'd3,
    CMD_WRC  = 3'd4,
    CMD_REFR = 3'd5
  } vcmd_e;

  typedef enum logic [1:0] {
    PH_PAUSE = 2'd0,
    PH_ADDR  = 2'd1,
    PH_STRB  = 2'd2,
    PH_PRE   = 2'd3
  } vph_e;

  localparam int SLOTS = 4;

  // Transfer issued by each slot of the main cycle: A, B, A, C.
  function automatic vcmd_e slot_cmd(input logic [1:0] s);
    case (s)
      2'd1:    return CMD_RDB;
      2'd3:    return CMD_WRC;
      default: return CMD_RDA;
    endcase
  endfunction

endpackage

// File: rtl/vsam_ref_timer.sv
module vsam_ref_timer
  import vsam_pkg::*;
#(
  parameter int REF_PERIOD = 6000,
  parameter int ROW_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             take_i,
  output logic             pend_o,
  output logic [ROW_W-1:0] ref_row_o
);

  localparam int TMR_W = (REF_PERIOD > 2) ? $clog2(REF_PERIOD) : 1;
  localparam logic [TMR_W-1:0] TMR_TOP = TMR_W'(REF_PERIOD - 1);

  logic [TMR_W-1:0] tmr_q;
  logic             pend_q;
  logic [ROW_W-1:0] row_q;
  logic             tick;

  assign tick = run_i && (tmr_q == '0);

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      tmr_q  <= TMR_TOP;
      pend_q <= 1'b0;
    end else begin
      tmr_q  <= tick ? TMR_TOP : tmr_q - TMR_W'(1);
      pend_q <= tick | (pend_q & ~take_i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         row_q <= '0;
    else if (take_i) row_q <= row_q + ROW_W'(1);
  end

  assign pend_o    = pend_q;
  assign ref_row_o = row_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (pend_q && tick) |-> take_i); // R7

  AST_REF_ROW_WRAP: assert property (@(posedge clk) disable iff (rst)
    (take_i && ($countones(row_q) == ROW_W)) |=> (row_q == '0)); // R8

endmodule

// File: rtl/vsam_slot_sched.sv
module vsam_slot_sched
  import vsam_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  pick_i,
  input  logic  pend_i,
  output vcmd_e next_o,
  output logic  take_o
);

  logic [1:0] slot_q;
  logic       at_edge;

  assign at_edge = (slot_q == 2'd0);
  assign take_o  = pick_i && pend_i && at_edge;
  assign next_o  = (pend_i && at_edge) ? CMD_REFR : slot_cmd(slot_q);

  always_ff @(posedge clk) begin
    if (rst)                    slot_q <= 2'd0;
    else if (pick_i && !take_o) slot_q <= slot_q + 2'd1;
  end

  AST_REF_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (slot_q == 2'd0)); // R6

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
    (pick_i && !take_o) |=> (slot_q == $past(slot_q) + 2'd1)); // R4

endmodule

// File: rtl/vsam_phase_gen.sv
module vsam_phase_gen
  import vsam_pkg::*;
#(
  parameter int PAUSE_CYC = 20000,
  parameter int ADDR_CYC  = 14,
  parameter int RE_CYC    = 12,
  parameter int PRE_CYC   = 4,
  parameter int INIT_N    = 8
) (
  input  logic  clk,
  input  logic  rst,
  input  vcmd_e next_i,
  output logic  pick_o,
  output logic  act_n_o,
  output logic  addr_o,
  output logic  re_o,
  output vcmd_e cmd_o,
  output logic  rdy_o
);

  localparam int M1    = (PAUSE_CYC > ADDR_CYC) ? PAUSE_CYC : ADDR_CYC;
  localparam int M2    = (RE_CYC > PRE_CYC) ? RE_CYC : PRE_CYC;
  localparam int MAXL  = (M1 > M2) ? M1 : M2;
  localparam int CNT_W = $clog2(MAXL + 1);
  localparam int INI_W = $clog2(INIT_N + 1);

  localparam logic [CNT_W-1:0] PAUSE_END = CNT_W'(PAUSE_CYC - 1);
  localparam logic [CNT_W-1:0] ADDR_END  = CNT_W'(ADDR_CYC - 1);
  localparam logic [CNT_W-1:0] RE_END    = CNT_W'(RE_CYC - 1);
  localparam logic [CNT_W-1:0] PRE_END   = CNT_W'(PRE_CYC - 1);
  localparam logic [INI_W-1:0] INIT_LAST = INI_W'(INIT_N - 1);

  vph_e             ph_q, ph_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  vcmd_e            op_q, op_n;
  logic [INI_W-1:0] ini_q, ini_n;
  logic             rdy_q, rdy_n;
  logic             pick;
  logic             act_n;

  always_comb begin
    ph_n  = ph_q;
    cnt_n = cnt_q + CNT_W'(1);
    op_n  = op_q;
    ini_n = ini_q;
    rdy_n = rdy_q;
    pick  = 1'b0;
    unique case (ph_q)
      PH_PAUSE: if (cnt_q == PAUSE_END) begin
        ph_n  = PH_STRB;
        cnt_n = '0;
        op_n  = CMD_INIT;
      end
      PH_ADDR: if (cnt_q == ADDR_END) begin
        ph_n  = PH_STRB;
        cnt_n = '0;
      end
      PH_STRB: if (cnt_q == RE_END) begin
        ph_n  = PH_PRE;
        cnt_n = '0;
      end
      PH_PRE: if (cnt_q == PRE_END) begin
        cnt_n = '0;
        if (!rdy_q && (ini_q != INIT_LAST)) begin
          ini_n = ini_q + INI_W'(1);
          op_n  = CMD_INIT;
          ph_n  = PH_STRB;
        end else begin
          rdy_n = 1'b1;
          pick  = 1'b1;
          op_n  = next_i;
          ph_n  = (next_i == CMD_REFR) ? PH_STRB : PH_ADDR;
        end
      end
    endcase
  end

  assign act_n = (ph_n == PH_ADDR) || (ph_n == PH_STRB);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_PAUSE;
      cnt_q  <= '0;
      op_q   <= CMD_IDLE;
      ini_q  <= '0;
      rdy_q  <= 1'b0;
      addr_o <= 1'b0;
      re_o   <= 1'b0;
      cmd_o  <= CMD_IDLE;
    end else begin
      ph_q   <= ph_n;
      cnt_q  <= cnt_n;
      op_q   <= op_n;
      ini_q  <= ini_n;
      rdy_q  <= rdy_n;
      addr_o <= (ph_n == PH_ADDR);
      re_o   <= (ph_n == PH_STRB);
      cmd_o  <= act_n ? op_n : CMD_IDLE;
    end
  end

  assign pick_o  = pick;
  assign act_n_o = act_n;
  assign rdy_o   = rdy_q;

  AST_READY_HOLD: assert property (@(posedge clk) disable iff (rst)
    rdy_q |=> rdy_q); // R3

  AST_INIT_BEFORE_READY: assert property (@(posedge clk) disable iff (rst)
    (!rdy_q && re_o) |-> (cmd_o == CMD_INIT)); // R2

  AST_ADDR_LEADS_RE: assert property (@(posedge clk) disable iff (rst)
    ($rose(re_o) && (cmd_o != CMD_INIT) && (cmd_o != CMD_REFR)) |-> $past(addr_o)); // R5

  AST_STRB_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(addr_o && re_o)); // R5

  AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_PAUSE) |-> (!re_o && !addr_o && !rdy_q)); // R1

endmodule

// File: rtl/vsam_cycle_seq.sv
module vsam_cycle_seq
  import vsam_pkg::*;
#(
  parameter int PAUSE_CYC  = 20000,
  parameter int ADDR_CYC   = 14,
  parameter int RE_CYC     = 12,
  parameter int PRE_CYC    = 4,
  parameter int INIT_N     = 8,
  parameter int REF_PERIOD = 6000,
  parameter int ROW_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ROW_W-1:0] row_a_i,
  input  logic [ROW_W-1:0] row_b_i,
  input  logic [ROW_W-1:0] row_c_i,
  output logic             addr_strb_o,
  output logic             re_strb_o,
  output logic [2:0]       cmd_o,
  output logic [ROW_W-1:0] row_o
  ,
  output logic             ready_o
);

  vcmd_e            next_cmd;
  vcmd_e            cmd_q;
  logic             pick;
  logic             act_n;
  logic             take;
  logic             pend;
  logic             rdy;
  logic [ROW_W-1:0] ref_row;
  logic [ROW_W-1:0] row_sel;
  logic [ROW_W-1:0] row_q;

  vsam_phase_gen #(
    .PAUSE_CYC (PAUSE_CYC),
    .ADDR_CYC  (ADDR_CYC),
    .RE_CYC    (RE_CYC),
    .PRE_CYC   (PRE_CYC),
    .INIT_N    (INIT_N)
  ) u_phase (
    .clk     (clk),
    .rst     (rst),
    .next_i  (next_cmd),
    .pick_o  (pick),
    .act_n_o (act_n),
    .addr_o  (addr_strb_o),
    .re_o    (re_strb_o),
    .cmd_o   (cmd_q),
    .rdy_o   (rdy)
  );

  vsam_slot_sched u_sched (
    .clk    (clk),
    .rst    (rst),
    .pick_i (pick),
    .pend_i (pend),
    .next_o (next_cmd),
    .take_o (take)
  );

  vsam_ref_timer #(
    .REF_PERIOD (REF_PERIOD),
    .ROW_W      (ROW_W)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .run_i     (rdy),
    .take_i    (take),
    .pend_o    (pend),
    .ref_row_o (ref_row)
  );

  always_comb begin
    unique case (next_cmd)
      CMD_RDB:  row_sel = row_b_i;
      CMD_WRC:  row_sel = row_c_i;
      CMD_REFR: row_sel = ref_row;
      default:  row_sel = row_a_i;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        row_q <= '0;
    else if (!act_n) row_q <= '0;
    else if (pick)  row_q <= row_sel;
  end

  assign cmd_o   = cmd_q;
  assign row_o   = row_q;
  assign ready_o = rdy;

  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (re_strb_o && $past(re_strb_o)) |-> $stable(row_o)); // R9

  AST_REF_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
    addr_strb_o |-> (cmd_q != CMD_REFR && cmd_q != CMD_INIT)); // R6

endmodule

// File: tb/sim_vsam_cycle_seq.sv
`timescale 1ns/1ps
module sim_vsam_cycle_seq;

  localparam int PAUSE = 50;
  localparam int ADDR  = 3;
  localparam int RE    = 4;
  localparam int PRE   = 2;
  localparam int REF   = 100;
  localparam int MAINL = 4 * (ADDR + RE + PRE) + (RE + PRE);

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] row_a = '0, row_b = '0, row_c = '0;
  logic       addr_s, re_s, rdy;
  logic [2:0] cmd;
  logic [7:0] row;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  vsam_cycle_seq #(
    .PAUSE_CYC(PAUSE), .ADDR_CYC(ADDR), .RE_CYC(RE), .PRE_CYC(PRE),
    .INIT_N(8), .REF_PERIOD(REF), .ROW_W(8)
  ) u0 (
    .clk(clk), .rst(rst), .row_a_i(row_a), .row_b_i(row_b), .row_c_i(row_c),
    .addr_strb_o(addr_s), .re_strb_o(re_s), .cmd_o(cmd), .row_o(row), .ready_o(rdy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: segment kind, cycles left in it, pending work.
  int m_seg, m_left, m_op, m_row, m_inits, m_k, m_slot, m_ref;
  bit m_rdy, m_pend;
  int pat [4] = '{2, 3, 2, 4};

  always @(posedge clk) begin
    bit old_rdy, tick, took;
    if (rst) begin
      m_seg = 0; m_left = PAUSE; m_op = 0; m_row = 0; m_inits = 0;
      m_k = 0; m_slot = 0; m_ref = 0; m_rdy = 0; m_pend = 0;
    end else begin
      old_rdy = m_rdy;
      tick = m_rdy && ((m_k % REF) == REF - 1);
      took = 0;
      if (m_left > 1) m_left--;
      else begin
        case (m_seg)
          0: begin m_seg = 2; m_left = RE; m_op = 1; m_row = 0; end
          1: begin m_seg = 2; m_left = RE; end
          2: begin m_seg = 3; m_left = PRE; end
          default: begin
            if (!m_rdy && m_inits < 7) begin
              m_inits++; m_seg = 2; m_left = RE; m_op = 1; m_row = 0;
            end else if (m_pend && m_slot == 0) begin
              m_rdy = 1; took = 1; m_op = 5; m_row = m_ref;
              m_ref = (m_ref + 1) % 256; m_seg = 2; m_left = RE;
            end else begin
              m_rdy = 1; m_op = pat[m_slot];
              m_row = (m_slot == 1) ? int'(row_b) : (m_slot == 3) ? int'(row_c) : int'(row_a);
              m_slot = (m_slot + 1) % 4; m_seg = 1; m_left = ADDR;
            end
          end
        endcase
      end
      if (!old_rdy) begin m_k = 0; m_pend = 0; end
      else begin m_pend = tick ? 1'b1 : (took ? 1'b0 : m_pend); m_k++; end
    end
  end

  // Per-cycle comparison against the reference.
  always @(negedge clk) begin
    bit act;
    if (!done && !rst) begin
      act = (m_seg == 1) || (m_seg == 2);
      chk(addr_s == (m_seg == 1), "R5 addr_strb", addr_s, m_seg == 1);
      chk(re_s == (m_seg == 2), "R5 re_strb", re_s, m_seg == 2);
      chk(int'(cmd) == (act ? m_op : 0), "R4 cmd", cmd, act ? m_op : 0);
      chk(int'(row) == (act ? m_row : 0), "R9 row", row, act ? m_row : 0);
      chk(rdy == m_rdy, "R3 ready", rdy, m_rdy);
    end
  end

  // Event-level checks that do not use the reference.
  int  since_rst, init_seen, ref_seen, gap, last_xfer, pat_idx, len_a, len_r, idle;
  int  ref_gap;
  bit  seen_re, p_addr, p_re, p_rdy, after_re, wrapped;
  logic [7:0] pa, pb, pc;
  int  last_ref_row;

  always @(negedge clk) begin
    if (rst) begin
      since_rst = 0; init_seen = 0; ref_seen = 0; seen_re = 0; p_addr = 0; p_re = 0;
      p_rdy = 0; after_re = 0; last_xfer = 4; pat_idx = 0; len_a = 0; len_r = 0;
      idle = 0; ref_gap = 0; last_ref_row = -1;
    end else if (!done) begin
      if (!seen_re && re_s) begin
        seen_re = 1;
        chk(since_rst == PAUSE, "R1 pause length", since_rst, PAUSE);
      end
      if (!seen_re) since_rst++;
      if (rdy && !p_rdy) chk(init_seen == 8, "R2 dummy count", init_seen, 8);
      if (rdy) ref_gap++;
      if (re_s && !p_re && cmd == 3'd1) begin
        init_seen++;
        chk(!rdy && row == 0, "R2 dummy idle row", row, 0);
      end
      if (addr_s && !p_addr) begin
        chk(int'(cmd) == pat[pat_idx], "R4 transfer order", cmd, pat[pat_idx]);
        pat_idx = (pat_idx + 1) % 4;
        case (cmd)
          3'd3: chk(row == pb, "R9 port B row", row, pb);
          3'd4: chk(row == pc, "R9 port C row", row, pc);
          default: chk(row == pa, "R9 port A row", row, pa);
        endcase
        last_xfer = int'(cmd);
      end
      if (re_s && !p_re && cmd == 3'd5) begin
        chk(last_xfer == 4, "R6 refresh at boundary", last_xfer, 4);
        chk(int'(row) == ref_seen % 256, "R8 refresh row", row, ref_seen % 256);
        chk(ref_gap <= REF + MAINL, "R7 refresh spacing", ref_gap, REF + MAINL);
        if (last_ref_row == 255 && row == 0) wrapped = 1;
        last_ref_row = int'(row);
        ref_seen++; ref_gap = 0;
      end
      if (p_addr && !addr_s) chk(len_a == ADDR, "R5 address length", len_a, ADDR);
      if (p_re && !re_s) begin
        chk(len_r == RE, "R5 strobe length", len_r, RE);
        after_re = 1; idle = 0;
      end
      if (after_re && (re_s || addr_s)) begin
        chk(idle == PRE, "R5 precharge gap", idle, PRE);
        after_re = 0;
      end
      if (after_re && !re_s && !addr_s) begin
        idle++;
        chk(cmd == 0 && row == 0, "R5 idle outputs", cmd, 0);
      end
      len_a = addr_s ? len_a + 1 : 0;
      len_r = re_s ? len_r + 1 : 0;
      p_addr = addr_s; p_re = re_s; p_rdy = rdy;
    end
    pa = row_a; pb = row_b; pc = row_c;
  end

  // Row input patterns, changed just after each rising edge.
  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    chk(!rdy && cmd == 0 && !re_s && !addr_s && row == 0, "R1 reset state", cmd, 0);
    for (int c = 0; c < 27000; c++) begin
      @(posedge clk); #1;
      if (c < 8000) begin
        row_a = 8'h11; row_b = 8'h22; row_c = 8'h33;
      end else if (c < 16000) begin
        lfsr  = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        row_a = lfsr[7:0]; row_b = lfsr[15:8]; row_c = lfsr[11:4];
      end else begin
        row_a = c[7:0]; row_b = ~c[7:0]; row_c = c[7:0] ^ 8'h5A;
      end
    end
    chk(ref_seen >= 250, "R7 refresh count", ref_seen, 250);
    chk(wrapped, "R8 counter wrap", wrapped, 1);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(!rdy && cmd == 0, "R10 restart after reset", rdy, 0);
    repeat (PAUSE + 8 * (RE + PRE) + 300) @(posedge clk);
    #1 chk(rdy, "R10 ready again", rdy, 1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule